// File: doc/BRIEF.md
# Byte-Wide SPI Host Controller

This block is an SPI host driven by software through a small byte-wide register bus. Writing a byte to the data port starts a full-duplex exchange of eight bits, most significant bit first. When the exchange finishes, the byte received on MISO goes into a small receive FIFO, and a read of the same data port takes it out. Software polls a status register: it waits for the receive-empty flag to drop after each byte. A completion flag and a collision flag are cleared by writing a 1 to their bit positions.

The clock polarity and sampling phase are set in the control register. The SCLK divide ratio is a power of two from 2 to 4096, selected by a four-bit code that is split across two registers. Four chip-select outputs are each under software control, with a separate enable bit and level bit. A parameter register holds a memory-path enable bit, which is brought out on a pin. Software clears it so that the data port owns the bus, and restores it afterwards.

Top module: `spi_byte_host`

## Requirements
- R1: When the controller is enabled and idle, a write to the data port (address 2) starts an exchange of that byte. Each received byte is returned by a read of address 2, and that read removes it; bytes come out in the order they were received.
- R2: The transmitted byte appears on MOSI most significant bit first, and the received byte is assembled from MISO most significant bit first.
- R3: The status register (address 1) has bit 0 set while the receive FIFO holds no byte, and clear once a received byte is stored. Bit 2 is set for as long as an exchange is in progress.
- R4: Status bit 7 is set when an exchange completes. A status write with bit 7 = 1 clears it; a status write with bit 7 = 0 leaves it unchanged.
- R5: A data-port write during an exchange sets status bit 6 and discards the new byte, so the exchange in progress and the FIFO are unaffected. A status write with bit 6 = 1 clears the flag.
- R6: Control register (address 0) bit 7 enables the controller. While it is 0, data-port writes start nothing and set no flag. Clearing it during an exchange aborts the exchange: SCLK returns to idle and no byte is stored.
- R7: Control bit 3 is the clock polarity and control bit 2 is the phase. SCLK rests at the polarity level when idle. With phase 0, MISO is sampled on the leading edge; with phase 1, it is sampled on the trailing edge.
- R8: The prescaler code is {ext[1:0], ctrl[1:0]}, where the extended register is address 3. Codes 0,1,4,2,3,5,6,7,8,9,10,11 select divisors 2,4,8,...,4096 in that order, and codes 12-15 select 4096. An exchange keeps status bit 2 set for 8 x divisor clock cycles.
- R9: The receive FIFO holds 4 bytes. Status bit 3 is set when it is full. A byte that completes while the FIFO is full is dropped.
- R10: For the chip-select register (address 4), cs_n[n] equals bit 4+n when bit n is 1, and is 1 when bit n is 0.
- R11: Bit 0 of the parameter register (address 5) drives mem_path_en. It is 1 after reset and reads back as written.
- R12: After reset, control reads 0x00, status reads 0x01, the chip-select register reads 0x00, all cs_n are 1 and SCLK is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops the FIFO at the data address) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Chip-select outputs |
| mem_path_en | output | 1 | Memory-path enable bit |

## Verification
The cases that are hardest to reach from the ports are the ones that depend on timing inside an exchange: a second data write that arrives while the shifter is busy, and a disable that lands in the middle of an exchange. The stimulus reaches both by selecting a slow prescaler code, so the exchange lasts over a hundred cycles, and then issuing the colliding write or the disable a few cycles after the start. The FIFO overflow case is reached by running five exchanges back to back without reading. A mode-aware slave model in the bench returns known bytes and captures MOSI, which checks bit order in all four clock modes.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;
    localparam int BYTE_W  = 8;
    localparam int MAX_EXP = 12;

    typedef logic [2:0] reg_addr_t;
    localparam reg_addr_t ADDR_CTRL  = 3'd0;
    localparam reg_addr_t ADDR_STAT  = 3'd1;
    localparam reg_addr_t ADDR_DATA  = 3'd2;
    localparam reg_addr_t ADDR_EXT   = 3'd3;
    localparam reg_addr_t ADDR_CS    = 3'd4;
    localparam reg_addr_t ADDR_PARAM = 3'd5;

    typedef struct packed {
        logic       en;
        logic [2:0] spare;
        logic       cpol;
        logic       cpha;
        logic [1:0] div_lo;
    } ctrl_t;

    // Divide exponent (divisor = 2**exp) for a four-bit prescaler code.
    function automatic logic [3:0] presc_exp(input logic [3:0] code);
        logic [3:0] e;
        case (code)
            4'd0:    e = 4'd1;
            4'd1:    e = 4'd2;
            4'd4:    e = 4'd3;
            4'd2:    e = 4'd4;
            4'd3:    e = 4'd5;
            default: e = (code >= 4'd11) ? 4'(MAX_EXP) : code + 4'd1;
        endcase
        return e;
    endfunction
endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
    parameter int MAX_EXP = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [3:0] exp_i,
    output logic       tick
);
    localparam int CNT_W = MAX_EXP;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_m1;

    always_comb begin
        half_m1 = (CNT_W'(1) << (exp_i - 4'd1)) - CNT_W'(1);
        tick    = run && (cnt_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= half_m1;
        else if (tick)   cnt_q <= half_m1;
        else             cnt_q <= cnt_q - CNT_W'(1);
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         start,
    input  logic [W-1:0] tx_byte,
    input  logic         cpol,
    input  logic         cpha,
    input  logic         tick,
    input  logic         miso,
    output logic         busy,
    output logic         sclk,
    output logic         mosi,
    output logic         done,
    output logic [W-1:0] rx_byte
);
    localparam int EDGES = 2 * W;
    localparam int EW    = $clog2(EDGES);

    logic         busy_q, phase_q;
    logic [EW-1:0] edge_q;
    logic [W-1:0] tx_sr, rx_sr, rx_next;
    logic         sample_now, shift_now;

    always_comb begin
        sample_now = tick && (edge_q[0] == cpha);
        shift_now  = tick && (edge_q[0] != cpha) && (edge_q != '0)
                     && (edge_q != EW'(EDGES - 1));
        done       = busy_q && tick && (edge_q == EW'(EDGES - 1));
        rx_next    = sample_now ? {rx_sr[W-2:0], miso} : rx_sr;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            busy_q  <= 1'b0;
            phase_q <= 1'b0;
            edge_q  <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q  <= 1'b1;
                phase_q <= 1'b0;
                edge_q  <= '0;
                tx_sr   <= tx_byte;
                rx_sr   <= '0;
            end
        end else if (tick) begin
            phase_q <= ~phase_q;
            edge_q  <= edge_q + EW'(1);
            rx_sr   <= rx_next;
            if (shift_now) tx_sr <= {tx_sr[W-2:0], 1'b0};
            if (done)      busy_q <= 1'b0;
        end
    end

    assign busy    = busy_q;
    assign sclk    = cpol ^ phase_q;
    assign mosi    = tx_sr[W-1];
    assign rx_byte = rx_next;

    assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> (sclk == cpol));
    assert_disable_idles_R6: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !busy_q);
endmodule

// File: rtl/spi_rx_fifo.sv
module spi_rx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          push_ok, pop_ok;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        empty   = (count == '0);
        full    = (count == CW'(DEPTH));
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        dout    = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= nxt(wr_ptr);
            end
            if (pop_ok) rd_ptr <= nxt(rd_ptr);
            if (push_ok && !pop_ok)      count <= count + CW'(1);
            else if (pop_ok && !push_ok) count <= count - CW'(1);
        end
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    assert_push_fills_R3: assert property (@(posedge clk) disable iff (rst)
        push |=> !empty);
endmodule

// File: rtl/spi_byte_host.sv
module spi_byte_host
    import spi_byte_pkg::*;
#(
    parameter int NUM_CS   = 4,
    parameter int RX_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n,
    output logic              mem_path_en
);
    ctrl_t      ctrl_q;
    logic [1:0] ext_q;
    logic [7:0] cs_q;
    logic       mem_en_q, done_q, wcol_q;

    logic wr_ctrl, wr_stat, wr_data, wr_ext, wr_cs, wr_param, rd_data;
    logic busy, tick, eng_done, start;
    logic [3:0] div_exp;
    logic [BYTE_W-1:0] eng_rx, fifo_dout;
    logic fifo_empty, fifo_full;

    always_comb begin
        wr_ctrl  = bus_wr && (bus_addr == ADDR_CTRL);
        wr_stat  = bus_wr && (bus_addr == ADDR_STAT);
        wr_data  = bus_wr && (bus_addr == ADDR_DATA);
        wr_ext   = bus_wr && (bus_addr == ADDR_EXT);
        wr_cs    = bus_wr && (bus_addr == ADDR_CS);
        wr_param = bus_wr && (bus_addr == ADDR_PARAM);
        rd_data  = bus_rd && (bus_addr == ADDR_DATA);
        start    = wr_data && ctrl_q.en && !busy;
        div_exp  = presc_exp({ext_q, ctrl_q.div_lo});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            ext_q    <= '0;
            cs_q     <= '0;
            mem_en_q <= 1'b1;
            done_q   <= 1'b0;
            wcol_q   <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q       <= ctrl_t'(bus_wdata);
                ctrl_q.spare <= '0;
            end
            if (wr_ext)   ext_q    <= bus_wdata[1:0];
            if (wr_cs)    cs_q     <= bus_wdata;
            if (wr_param) mem_en_q <= bus_wdata[0];
            if (eng_done)                     done_q <= 1'b1;
            else if (wr_stat && bus_wdata[7]) done_q <= 1'b0;
            if (wr_data && ctrl_q.en && busy) wcol_q <= 1'b1;
            else if (wr_stat && bus_wdata[6]) wcol_q <= 1'b0;
        end
    end

    spi_half_tick #(.MAX_EXP(MAX_EXP)) u_tick (
        .clk(clk), .rst(rst), .run(busy), .exp_i(div_exp), .tick(tick)
    );

    spi_shift_engine #(.W(BYTE_W)) u_eng (
        .clk(clk), .rst(rst), .enable(ctrl_q.en), .start(start),
        .tx_byte(bus_wdata), .cpol(ctrl_q.cpol), .cpha(ctrl_q.cpha),
        .tick(tick), .miso(miso), .busy(busy), .sclk(sclk), .mosi(mosi),
        .done(eng_done), .rx_byte(eng_rx)
    );

    spi_rx_fifo #(.W(BYTE_W), .DEPTH(RX_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(eng_done), .din(eng_rx), .pop(rd_data),
        .dout(fifo_dout), .empty(fifo_empty), .full(fifo_full)
    );

    for (genvar n = 0; n < NUM_CS; n++) begin : g_cs
        assign cs_n[n] = cs_q[n] ? cs_q[4+n] : 1'b1;
    end

    assign mem_path_en = mem_en_q;

    always_comb begin
        case (bus_addr)
            ADDR_CTRL:  bus_rdata = ctrl_q;
            ADDR_STAT:  bus_rdata = {done_q, wcol_q, 2'b00, fifo_full, busy, 1'b0, fifo_empty};
            ADDR_DATA:  bus_rdata = fifo_dout;
            ADDR_EXT:   bus_rdata = {6'b0, ext_q};
            ADDR_CS:    bus_rdata = cs_q;
            ADDR_PARAM: bus_rdata = {7'b0, mem_en_q};
            default:    bus_rdata = '0;
        endcase
    end

    assert_wcol_set_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_data && ctrl_q.en && busy) |=> wcol_q);
    assert_done_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && bus_wdata[7] && !eng_done) |=> !done_q);
    assert_cs_stable_R10: assert property (@(posedge clk) disable iff (rst)
        !wr_cs |=> $stable(cs_n));
endmodule

// File: tb/tb_spi_byte_host.sv
module tb_spi_byte_host;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sclk, mosi, miso;
    logic [3:0] cs_n;
    logic       mem_path_en;

    always #2 clk = ~clk;

    spi_byte_host dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_n(cs_n), .mem_path_en(mem_path_en)
    );

    int n_checks = 0, n_fail = 0;
    bit reported = 0;
    int level = 0;
    logic [7:0] exp_q [$];

    // Mode-aware slave model.
    logic [7:0] slv_tx = '0, slv_cap = '0;
    logic slv_cpol = 0, slv_cpha = 0, slv_armed = 0;
    int   slv_edges = 0;
    assign miso = slv_tx[7];
    always @(sclk) begin
        if (slv_armed) begin
            if ((sclk != slv_cpol) ^ slv_cpha) slv_cap <= {slv_cap[6:0], mosi};
            else if (slv_edges != 0)           slv_tx  <= {slv_tx[6:0], 1'b0};
            slv_edges <= slv_edges + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FIL%s %s: actual %0h expected %0h", "", req, act, exp);
        end
    endtask

    // Scoreboard monitor: compares each data-port read against the queue.
    always @(negedge clk) begin
        if (bus_rd && bus_addr == 3'd2) begin
            if (exp_q.size() == 0) check(0, "R1 unexpected pop", bus_rdata, 0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(bus_rdata == e, "R1 received byte", bus_rdata, e);
            end
        end
    end

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic drain(input int n);
        logic [7:0] d;
        for (int i = 0; i < n; i++) begin
            bus_read(3'd2, d);
            if (level > 0) level--;
        end
    endtask

    task automatic wait_idle(output int cnt, output logic [7:0] first);
        logic [7:0] st;
        cnt = 0;
        bus_addr = 3'd1;
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk); st = bus_rdata;
            if (i == 0) first = st;
            if (!st[2]) break;
            cnt++;
        end
    endtask

    task automatic do_xfer(input logic [7:0] tx, input logic [7:0] sb, input logic cpol,
                           input logic cpha, input logic [3:0] code, input int div);
        int cnt; logic [7:0] first, st;
        bit had_room;
        bus_write(3'd3, {6'b0, code[3:2]});
        bus_write(3'd0, {1'b1, 3'b0, cpol, cpha, code[1:0]});
        slv_cpol = cpol; slv_cpha = cpha; slv_tx = sb; slv_cap = '0; slv_edges = 0;
        slv_armed = 1;
        bus_write(3'd2, tx);
        wait_idle(cnt, first);
        slv_armed = 0;
        check(first[2] == 1'b1, "R3 busy during exchange", first, 8'h04);
        check(first[0] == (level == 0), "R3 empty before completion", first[0], level == 0);
        check(cnt == 8 * div, "R8 exchange length", cnt, 8 * div);
        @(negedge clk); st = bus_rdata;
        check(st[0] == 1'b0 && st[7] == 1'b1, "R3/R4 byte stored, done set", st, 8'h80);
        check(slv_cap == tx, "R2 MOSI bit order", slv_cap, tx);
        check(sclk == cpol, "R7 SCLK idle level", sclk, cpol);
        had_room = (level < 4);
        check(st[3] == (level >= 3), "R9 full flag", st[3], level >= 3);
        if (had_room) begin exp_q.push_back(sb); level++; end
        bus_write(3'd1, 8'h80);
    endtask

    task automatic finish_run();
        if (!reported) begin
            reported = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d; int cnt; logic [7:0] first;
        repeat (3) @(posedge clk); #1 rst = 1'b0;
        // R12 reset state
        @(negedge clk);
        check(cs_n == 4'hF, "R12 cs_n reset", cs_n, 4'hF);
        check(sclk == 1'b0, "R12 sclk reset", sclk, 0);
        check(mem_path_en == 1'b1, "R11 mem enable reset", mem_path_en, 1);
        bus_read(3'd0, d); check(d == 8'h00, "R12 ctrl reset", d, 8'h00);
        bus_read(3'd1, d); check(d == 8'h01, "R12 status reset", d, 8'h01);
        bus_read(3'd4, d); check(d == 8'h00, "R12 cs reg reset", d, 8'h00);

        // R6 disabled: data write ignored
        bus_write(3'd2, 8'hAA);
        @(negedge clk); bus_addr = 3'd1; @(negedge clk);
        check(bus_rdata == 8'h01, "R6 write ignored while disabled", bus_rdata, 8'h01);

        // R1 R2 R7 in four modes, R8 timings
        do_xfer(8'hA5, 8'h3C, 0, 0, 4'd0, 2);    drain(1);
        do_xfer(8'h96, 8'hC3, 0, 1, 4'd1, 4);    drain(1);
        do_xfer(8'h01, 8'h80, 1, 0, 4'd4, 8);    drain(1);
        do_xfer(8'h7E, 8'hE7, 1, 1, 4'd2, 16);   drain(1);
        do_xfer(8'h5A, 8'h11, 0, 0, 4'd3, 32);   drain(1);
        do_xfer(8'h0F, 8'hF0, 1, 1, 4'd5, 64);   drain(1);
        do_xfer(8'hC9, 8'h2B, 0, 1, 4'd15, 4096); drain(1);

        // R9 FIFO fill and overflow drop
        for (int i = 0; i < 5; i++) do_xfer(8'(i), 8'(8'h40 + i), 0, 0, 4'd0, 2);
        drain(4);
        @(negedge clk); bus_addr = 3'd1; @(negedge clk);
        check(bus_rdata[0] == 1'b1, "R9 fifth byte dropped", bus_rdata, 1);

        // R5 collision, R4 write-one-to-clear
        bus_write(3'd3, 8'h00);
        bus_write(3'd0, 8'h82);
        slv_cpol = 0; slv_cpha = 0; slv_tx = 8'h5A; slv_cap = '0; slv_edges = 0; slv_armed = 1;
        bus_write(3'd2, 8'h33);
        bus_write(3'd2, 8'hFF);
        @(negedge clk); bus_addr = 3'd1; @(negedge clk);
        check(bus_rdata[6] == 1'b1, "R5 collision flag", bus_rdata, 8'h40);
        wait_idle(cnt, first);
        slv_armed = 0;
        check(slv_cap == 8'h33, "R5 colliding byte discarded", slv_cap, 8'h33);
        exp_q.push_back(8'h5A); level++;
        drain(1);
        @(negedge clk); bus_addr = 3'd1; @(negedge clk);
        check(bus_rdata[0] == 1'b1, "R5 only one byte stored", bus_rdata, 1);
        bus_write(3'd1, 8'h40);
        @(negedge clk); bus_addr = 3'd1; @(negedge clk);
        check(bus_rdata[6] == 1'b0, "R5 collision cleared", bus_rdata[6], 0);
        check(bus_rdata[7] == 1'b1, "R4 zero write keeps done", bus_rdata[7], 1);
        bus_write(3'd1, 8'h80);
        @(negedge clk); bus_addr = 3'd1; @(negedge clk);
        check(bus_rdata[7] == 1'b0, "R4 done cleared", bus_rdata[7], 0);

        // R6 abort mid exchange
        bus_write(3'd2, 8'h99);
        repeat (20) @(posedge clk);
        bus_write(3'd0, 8'h02);
        @(negedge clk); bus_addr = 3'd1; @(negedge clk);
        check(bus_rdata[2] == 1'b0 && sclk == 1'b0, "R6 abort to idle", bus_rdata, 8'h01);
        repeat (300) @(posedge clk);
        @(negedge clk);
        check(bus_rdata[0] == 1'b1 && bus_rdata[7] == 1'b0, "R6 abort stores nothing", bus_rdata, 8'h01);

        // R10 chip selects
        bus_write(3'd4, 8'h0F); @(negedge clk);
        check(cs_n == 4'h0, "R10 enabled low", cs_n, 4'h0);
        bus_write(3'd4, 8'h12); @(negedge clk);
        check(cs_n == 4'hD, "R10 mixed enable", cs_n, 4'hD);
        bus_write(3'd4, 8'hC8); @(negedge clk);
        check(cs_n == 4'hF, "R10 high level", cs_n, 4'hF);

        // R11 parameter register
        bus_write(3'd5, 8'h00); @(negedge clk);
        check(mem_path_en == 1'b0, "R11 cleared", mem_path_en, 0);
        bus_read(3'd5, d); check(d == 8'h00, "R11 readback", d, 0);
        bus_write(3'd5, 8'h01); @(negedge clk);
        check(mem_path_en == 1'b1, "R11 restored", mem_path_en, 1);

        check(exp_q.size() == 0, "R1 all bytes read", exp_q.size(), 0);
        finish_run();
    end
endmodule